// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This block keeps the interrupt bookkeeping of a memory-mapped I2C master controller. It keeps a six-bit pending-status register that is set by single-cycle event pulses from the transfer engine. It also keeps an enable mask, and it drives one level-sensitive interrupt line that is registered from the AND of status and mask. Software reaches the unit through a simple register port: a read strobe, a write strobe, a word offset and a 16-bit write value. Read data comes back on the clock edge after the read strobe.

The unit has two compatibility behaviours, selected by a static revision input. When the revision is below 0x34, the unit runs in the legacy behaviour. Status cannot be written, the mask holds five bits, and reading the vector register hands out the lowest pending enabled source and clears it. When the revision is 0x34 or above, the unit runs in the newer behaviour. Status is cleared by writing ones, the mask holds six bits, the vector read has no side effect, a test write forces every source pending, and a control write performs a soft reset. Register offsets: 0x00 revision, 0x04 mask, 0x08 status, 0x0C vector, 0x20 system control, 0x3C system test. Any other offset reads as zero.

Top module: `i2c_irq_status`

## Requirements
- R1: `irq` is a register. It goes high one clock after status AND mask becomes non-zero, and low one clock after that AND becomes zero. A pending source whose mask bit is zero never raises it.
- R2: A read of offset 0x00 returns `revId` zero-extended. Values of 0x34 and above select the newer behaviour; lower values select the legacy behaviour.
- R3: In legacy behaviour, a read of offset 0x0C returns the one-based index of the lowest set bit of status AND mask, or 0 if none is set. The same read clears that status bit.
- R4: In newer behaviour, a read of offset 0x0C returns the same index but leaves status unchanged.
- R5: In newer behaviour, a write to offset 0x08 clears each status bit [5:0] whose written bit is 1 and leaves the other bits unchanged.
- R6: In legacy behaviour, a write to offset 0x08 leaves status unchanged.
- R7: A write to offset 0x04 stores bits [4:0] in legacy behaviour, with bit 5 stored as 0. It stores bits [5:0] in newer behaviour. A read returns the stored mask.
- R8: A read of offset 0x08 returns status in bits [5:0] and `busBusy` in bit 12. All other bits read 0.
- R9: In newer behaviour, a write to offset 0x3C with bit 11 set makes status 0x3F. In legacy behaviour the same write has no effect.
- R10: In newer behaviour, a write to offset 0x20 with bit 1 set clears status and mask. This includes events arriving in that same cycle. Without bit 1, or in legacy behaviour, the write has no effect.
- R11: If an event pulse and a clear hit the same status bit in one cycle, the bit stays set. The clear can come from a status write or from a legacy vector read.
- R12: An event pulse on `evtPulse[i]` sets status bit i at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| revId | input | 8 | Static revision value; selects the behaviour |
| evtPulse | input | 6 | Single-cycle event pulses from the transfer engine |
| busBusy | input | 1 | Bus-busy level, reported in the status read |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 6 | Register byte offset |
| regWdata | input | 16 | Write value |
| regRdata | output | 16 | Read value, valid the cycle after `regRd` |
| irq | output | 1 | Level interrupt request |

## Verification
Two actions can land on the same status bit in one cycle: an event pulse, and a clear. In the newer behaviour the clear is a write-one status write. In the legacy behaviour it is the clearing vector read. The bench drives both in the same cycle, once per behaviour, on one shared bit. In the newer case it also clears a second bit that has no event, so a clear that is dropped altogether is caught. A scoreboard then compares the following status read against a value where the event bit survives and the plain clear takes effect.

// File: rtl/isu_pkg.sv
package isu_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_REV,
    SEL_MASK,
    SEL_STAT,
    SEL_VEC
  } rdSel_e;

  typedef struct packed {
    logic   maskWr;
    logic   statClr;
    logic   vecClr;
    logic   forceAll;
    logic   softRst;
    logic   newMode;
    logic   rdEn;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/isu_ctrl.sv
module isu_ctrl
  import isu_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          REV_W    = 8,
  parameter logic [7:0]  NEW_REV  = 8'h34,
  parameter logic [5:0]  OFF_REV  = 6'h00,
  parameter logic [5:0]  OFF_MASK = 6'h04,
  parameter logic [5:0]  OFF_STAT = 6'h08,
  parameter logic [5:0]  OFF_VEC  = 6'h0C,
  parameter logic [5:0]  OFF_SCTL = 6'h20,
  parameter logic [5:0]  OFF_TEST = 6'h3C
) (
  input  logic [REV_W-1:0]  revId,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              testForceBit,
  input  logic              softRstBit,
  output strobes_t          stb
);

  logic newMode;
  assign newMode = (revId >= REV_W'(NEW_REV));

  always_comb begin
    stb          = '0;
    stb.newMode  = newMode;
    stb.rdEn     = regRd;
    stb.maskWr   = regWr && (regAddr == ADDR_W'(OFF_MASK));
    stb.statClr  = regWr && newMode && (regAddr == ADDR_W'(OFF_STAT));
    stb.vecClr   = regRd && !newMode && (regAddr == ADDR_W'(OFF_VEC));
    stb.forceAll = regWr && newMode && testForceBit && (regAddr == ADDR_W'(OFF_TEST));
    stb.softRst  = regWr && newMode && softRstBit && (regAddr == ADDR_W'(OFF_SCTL));
    if (regAddr == ADDR_W'(OFF_REV))       stb.rdSel = SEL_REV;
    else if (regAddr == ADDR_W'(OFF_MASK)) stb.rdSel = SEL_MASK;
    else if (regAddr == ADDR_W'(OFF_STAT)) stb.rdSel = SEL_STAT;
    else if (regAddr == ADDR_W'(OFF_VEC))  stb.rdSel = SEL_VEC;
    else                                   stb.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/isu_datapath.sv
module isu_datapath
  import isu_pkg::*;
#(
  parameter int SRC_W    = 6,
  parameter int LEG_W    = 5,
  parameter int DATA_W   = 16,
  parameter int REV_W    = 8,
  parameter int BUSY_BIT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [SRC_W-1:0]  evtPulse,
  input  logic [SRC_W-1:0]  wrBits,
  input  logic [REV_W-1:0]  revId,
  input  logic              busBusy,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic [SRC_W-1:0]  statQ,
  output logic [SRC_W-1:0]  maskQ
);

  localparam int VEC_W = $clog2(SRC_W + 1);
  localparam logic [SRC_W-1:0] LEG_KEEP = SRC_W'((1 << LEG_W) - 1);

  logic [SRC_W-1:0]  pend;
  logic [SRC_W-1:0]  vecHot;
  logic [VEC_W-1:0]  vecIdx;
  logic [SRC_W-1:0]  clrBits;
  logic [SRC_W-1:0]  statD;
  logic [SRC_W-1:0]  maskD;
  logic [SRC_W-1:0]  maskWrVal;
  logic [DATA_W-1:0] statWord;

  assign pend = statQ & maskQ;

  // Lowest pending enabled source wins: scan from the top so the last hit stays.
  always_comb begin
    vecIdx = '0;
    vecHot = '0;
    for (int i = SRC_W - 1; i >= 0; i--) begin
      if (pend[i]) begin
        vecIdx    = VEC_W'(i + 1);
        vecHot    = '0;
        vecHot[i] = 1'b1;
      end
    end
  end

  assign clrBits   = (stb.statClr ? wrBits : '0) | (stb.vecClr ? vecHot : '0);
  assign maskWrVal = stb.newMode ? wrBits : (wrBits & LEG_KEEP);

  // Soft reset beats everything; an event beats a clear on the same bit.
  always_comb begin
    if (stb.softRst) begin
      statD = '0;
      maskD = '0;
    end else begin
      statD = (statQ & ~clrBits) | (stb.forceAll ? '1 : '0) | evtPulse;
      maskD = stb.maskWr ? maskWrVal : maskQ;
    end
  end

  always_comb begin
    statWord                = '0;
    statWord[SRC_W-1:0]     = statQ;
    statWord[BUSY_BIT]      = busBusy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ  <= '0;
      maskQ  <= '0;
      irq    <= 1'b0;
      rdData <= '0;
    end else begin
      statQ <= statD;
      maskQ <= maskD;
      irq   <= |pend;
      if (stb.rdEn) begin
        case (stb.rdSel)
          SEL_REV:  rdData <= DATA_W'(revId);
          SEL_MASK: rdData <= DATA_W'(maskQ);
          SEL_STAT: rdData <= statWord;
          SEL_VEC:  rdData <= DATA_W'(vecIdx);
          default:  rdData <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import isu_pkg::*;
#(
  parameter int SRC_W     = 6,
  parameter int LEG_W     = 5,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int REV_W     = 8,
  parameter int BUSY_BIT  = 12,
  parameter int TEST_BIT  = 11,
  parameter int SRST_BIT  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REV_W-1:0]  revId,
  input  logic [SRC_W-1:0]  evtPulse,
  input  logic              busBusy,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq
);

  strobes_t         stb;
  logic [SRC_W-1:0] statQ;
  logic [SRC_W-1:0] maskQ;
  logic             unusedWdata;

  assign unusedWdata = ^regWdata;

  isu_ctrl #(
    .ADDR_W(ADDR_W),
    .REV_W (REV_W)
  ) u_ctrl (
    .revId       (revId),
    .regWr       (regWr),
    .regRd       (regRd),
    .regAddr     (regAddr),
    .testForceBit(regWdata[TEST_BIT]),
    .softRstBit  (regWdata[SRST_BIT]),
    .stb         (stb)
  );

  isu_datapath #(
    .SRC_W   (SRC_W),
    .LEG_W   (LEG_W),
    .DATA_W  (DATA_W),
    .REV_W   (REV_W),
    .BUSY_BIT(BUSY_BIT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .evtPulse(evtPulse),
    .wrBits  (regWdata[SRC_W-1:0]),
    .revId   (revId),
    .busBusy (busBusy),
    .rdData  (regRdata),
    .irq     (irq),
    .statQ   (statQ),
    .maskQ   (maskQ)
  );

endmodule

// File: rtl/i2c_irq_status_chk.sv
module i2c_irq_status_chk (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  revId,
  input logic [5:0]  evtPulse,
  input logic        regWr,
  input logic        regRd,
  input logic [5:0]  regAddr,
  input logic [15:0] regWdata,
  input logic        irq,
  input logic [5:0]  statQ,
  input logic [5:0]  maskQ
);

  logic newMode;
  logic softHit;
  assign newMode = (revId >= 8'h34);
  assign softHit = newMode && regWr && (regAddr == 6'h20) && regWdata[1];

  // R1: an enabled pending source raises the line on the next edge
  p_irq_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    (|(statQ & maskQ)) |=> irq);

  // R12 (and R11: a same-cycle clear cannot remove the event)
  p_evt_sets_r12: assert property (@(posedge clk) disable iff (!rstN)
    ((|evtPulse) && !softHit) |=> ((statQ & $past(evtPulse)) == $past(evtPulse)));

  p_legacy_ro_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!newMode && regWr && !regRd && (regAddr == 6'h08) && (evtPulse == 6'h00))
      |=> $stable(statQ));

  p_mask_width_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!newMode && regWr && (regAddr == 6'h04)) |=> !maskQ[5]);

  p_force_all_r9: assert property (@(posedge clk) disable iff (!rstN)
    (newMode && regWr && (regAddr == 6'h3C) && regWdata[11]) |=> (statQ == 6'h3F));

  p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rstN)
    softHit |=> ((statQ == 6'h00) && (maskQ == 6'h00)));

endmodule

bind i2c_irq_status i2c_irq_status_chk u_isu_chk (
  .clk     (clk),
  .rstN    (rstN),
  .revId   (revId),
  .evtPulse(evtPulse),
  .regWr   (regWr),
  .regRd   (regRd),
  .regAddr (regAddr),
  .regWdata(regWdata),
  .irq     (irq),
  .statQ   (statQ),
  .maskQ   (maskQ)
);

// File: tb/test_i2c_irq_status.sv
`timescale 1ns/1ps
module test_i2c_irq_status;

  localparam logic [5:0] A_REV  = 6'h00;
  localparam logic [5:0] A_MASK = 6'h04;
  localparam logic [5:0] A_STAT = 6'h08;
  localparam logic [5:0] A_VEC  = 6'h0C;
  localparam logic [5:0] A_SCTL = 6'h20;
  localparam logic [5:0] A_TEST = 6'h3C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  revId = 8'h11;
  logic [5:0]  evtPulse = '0;
  logic        busBusy = 1'b0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int expQ[$];
  string tagQ[$];
  logic rdPend = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  i2c_irq_status i_i2c_irq_status (
    .clk(clk), .rstN(rstN), .revId(revId), .evtPulse(evtPulse),
    .busBusy(busBusy), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  task automatic compare(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Driver: one access per two half-cycles; reads push their expected value.
  task automatic access(input logic wr, input logic rd, input logic [5:0] a,
                        input logic [15:0] d, input logic [5:0] ev,
                        input int exp, input string tag);
    @(negedge clk);
    regWr = wr; regRd = rd; regAddr = a; regWdata = d; evtPulse = ev;
    if (rd) begin
      expQ.push_back(exp);
      tagQ.push_back(tag);
    end
    @(negedge clk);
    regWr = 1'b0; regRd = 1'b0; evtPulse = '0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    access(1'b1, 1'b0, a, d, 6'h00, 0, "");
  endtask

  task automatic rd(input logic [5:0] a, input int exp, input string tag);
    access(1'b0, 1'b1, a, 16'h0, 6'h00, exp, tag);
  endtask

  task automatic evt(input logic [5:0] ev);
    access(1'b0, 1'b0, 6'h00, 16'h0, ev, 0, "");
  endtask

  // Monitor: read data is valid at the negedge after the strobe's edge.
  always @(posedge clk) rdPend <= regRd;
  always @(negedge clk) begin
    if (rdPend) begin
      if (expQ.size() == 0) begin
        compare(0, 1, "scoreboard unexpected read");
      end else begin
        compare(int'(regRdata), expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(int'(regRdata), 0, "reset rdata R8");
    compare(int'(irq), 0, "reset irq R1");
    rstN = 1'b1;
    @(negedge clk);

    // Legacy behaviour
    rd(A_REV, 16'h0011, "R2 legacy revision");
    wr(A_MASK, 16'h003F);
    rd(A_MASK, 16'h001F, "R7 legacy mask width");
    evt(6'b001010);
    compare(int'(irq), 0, "R1 irq lag one cycle");
    @(negedge clk);
    compare(int'(irq), 1, "R1 irq raised");
    busBusy = 1'b1;
    rd(A_STAT, 16'h100A, "R8 R12 status with busy");
    rd(A_VEC, 2, "R3 vector lowest bit1");
    rd(A_STAT, 16'h1008, "R3 vector read cleared bit1");
    rd(A_VEC, 4, "R3 vector bit3");
    rd(A_VEC, 0, "R3 vector empty");
    busBusy = 1'b0;
    rd(A_STAT, 16'h0000, "R3 status empty");
    @(negedge clk);
    compare(int'(irq), 0, "R1 irq dropped");
    evt(6'b000001);
    wr(A_STAT, 16'h003F);
    rd(A_STAT, 16'h0001, "R6 legacy status write ignored");
    wr(A_TEST, 16'h0800);
    rd(A_STAT, 16'h0001, "R9 legacy force ignored");
    wr(A_SCTL, 16'h0002);
    rd(A_MASK, 16'h001F, "R10 legacy soft reset ignored");
    rd(A_VEC, 1, "R3 vector bit0");
    evt(6'b000100);
    access(1'b0, 1'b1, A_VEC, 16'h0, 6'b000100, 3, "R11 legacy vector with event");
    rd(A_STAT, 16'h0004, "R11 event survives vector clear");

    // Newer behaviour
    @(negedge clk);
    revId = 8'h34;
    rd(A_REV, 16'h0034, "R2 newer revision");
    wr(A_MASK, 16'h003F);
    rd(A_MASK, 16'h003F, "R7 newer mask width");
    rd(A_VEC, 3, "R4 vector value");
    rd(A_STAT, 16'h0004, "R4 vector read no clear");
    wr(A_STAT, 16'h0004);
    rd(A_STAT, 16'h0000, "R5 write one clears");
    @(negedge clk);
    compare(int'(irq), 0, "R1 irq low after clear");
    wr(A_TEST, 16'h0800);
    rd(A_STAT, 16'h003F, "R9 force all pending");
    compare(int'(irq), 1, "R1 irq after force");
    wr(A_STAT, 16'h0015);
    rd(A_STAT, 16'h002A, "R5 partial clear");
    access(1'b1, 1'b0, A_STAT, 16'h000A, 6'b000010, 0, "");
    rd(A_STAT, 16'h0022, "R11 event beats write clear");
    wr(A_SCTL, 16'h0001);
    rd(A_STAT, 16'h0022, "R10 no reset without bit1");
    wr(A_SCTL, 16'h0002);
    rd(A_STAT, 16'h0000, "R10 soft reset status");
    rd(A_MASK, 16'h0000, "R10 soft reset mask");
    @(negedge clk);
    compare(int'(irq), 0, "R1 irq low after soft reset");
    evt(6'b100000);
    @(negedge clk);
    @(negedge clk);
    compare(int'(irq), 0, "R1 masked source stays quiet");
    wr(A_MASK, 16'h0020);
    @(negedge clk);
    compare(int'(irq), 1, "R1 unmask raises irq");
    rd(A_SCTL, 16'h0000, "R2 unmapped read zero");

    repeat (3) @(negedge clk);
    compare(expQ.size(), 0, "scoreboard drained");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule